// File: doc/BRIEF.md
# Single-Window Surface Read Cache

This block sits between a pixel access port and a memory port. It keeps one aligned 4096-byte window of a surface in local storage so that a run of small reads to nearby pixels costs one memory burst instead of one memory access per pixel. A read names a byte offset and a width of one, two or four bytes. When the window that holds the offset is not resident, the block fetches the whole aligned window as a burst of 32-bit beats, marks it resident, then returns the requested value.

Writes are never merged into the window. Each write drops the resident window and is forwarded to memory with a byte count, so the next read always sees memory as it is. A packed-colour mode without alpha reads a 32-bit pixel with its top byte forced to all ones, and writes only the three colour bytes. A separate invalidate input drops the window when the surface is released.

Top module: `win_read_cache`

## Requirements
- R1: After reset `busy`, `rsp_valid`, `fill_req_valid` and `mw_valid` are low and no window is resident, so the first read misses.
- R2: A read whose aligned base (offset with its low 12 bits cleared) differs from the resident base raises exactly one fill request at that aligned base, held stable until `fill_req_ready`.
- R3: A fill consumes 1024 beats in order into words 0 to 1023 of the window; `busy` stays high until the fill ends and the read response follows it with `busy` low.
- R4: A read inside the resident window raises no fill request and its response appears in the cycle after the request is taken.
- R5: `req_size` 0 returns one byte, 1 returns two bytes, 2 returns four bytes, little-endian from window byte offset `req_addr[11:0]`, zero-extended to 32 bits.
- R6: `req_size` 3 is the packed-colour mode: a read returns the 32-bit word with bits 31:24 forced to 0xFF.
- R7: A write is sent to memory at `req_addr` unchanged with `mw_count` 1, 2, 4 or 3 for `req_size` 0, 1, 2, 3; bytes of `mw_data` beyond the count are zero, and the request holds until `mw_ready`.
- R8: Any write, of any size, drops the resident window; the next read refetches.
- R9: A pulse on `inval` drops the resident window; the next read refetches.
- R10: An `inval` that arrives during a fill still lets the pending read complete with correct data, but the window is left non-resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset into the surface |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 packed colour |
| req_wdata | input | 32 | Write value, low bytes first |
| busy | output | 1 | Block cannot take a request |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 32 | Read value |
| inval | input | 1 | Drop the resident window |
| fill_req_valid | output | 1 | Window fetch request |
| fill_addr | output | ADDR_W | Aligned window base to fetch |
| fill_req_ready | input | 1 | Memory accepts the fetch request |
| beat_valid | input | 1 | Fill beat present |
| beat_data | input | 32 | Fill beat value |
| beat_ready | output | 1 | Block accepts fill beats |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | ADDR_W | Write byte offset |
| mw_data | output | 32 | Write bytes, low first |
| mw_count | output | 3 | Number of bytes to write |
| mw_ready | input | 1 | Memory accepts the write |

## Verification
The assertions take for granted that requests arrive only while `busy` is low, that every access is naturally aligned so it stays inside one window, that the memory sends exactly 1024 beats and only after taking the fill request, and that `inval` never shares a cycle with a request. The driver waits for `busy` to fall before each request, uses only aligned offsets, and pulses `inval` only between requests or in the middle of a fill. The memory responder in the bench answers every fill with a full burst, inserting idle gaps between beats, and answers each write after a short delay.

// File: rtl/win_cache_pkg.sv
package win_cache_pkg;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RGB  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_REQ,
        ST_FILL_DATA,
        ST_RESP,
        ST_WRITE
    } ctl_state_e;

    typedef struct packed {
        logic [1:0] lane;
        acc_size_e  size;
    } rd_sel_t;

    // Select the addressed value out of a stored word.
    function automatic logic [WORD_W-1:0] pick_value(input logic [WORD_W-1:0] w,
                                                     input rd_sel_t s);
        logic [WORD_W-1:0] sh;
        sh = w >> {s.lane, 3'b000};
        unique case (s.size)
            SZ_BYTE: pick_value = {24'h0, sh[7:0]};
            SZ_HALF: pick_value = {16'h0, sh[15:0]};
            SZ_WORD: pick_value = w;
            default: pick_value = {8'hFF, w[23:0]};
        endcase
    endfunction

    function automatic logic [2:0] byte_count(input acc_size_e s);
        unique case (s)
            SZ_BYTE: byte_count = 3'd1;
            SZ_HALF: byte_count = 3'd2;
            SZ_WORD: byte_count = 3'd4;
            default: byte_count = 3'd3;
        endcase
    endfunction

    // Zero every byte lane at or above the count.
    function automatic logic [WORD_W-1:0] keep_bytes(input logic [WORD_W-1:0] w,
                                                     input logic [2:0] n);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (k < int'(n)) r[8*k +: 8] = w[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wc_tag.sv
module wc_tag #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit,
    output logic              valid
);
    localparam logic [ADDR_W-1:0] NONE = '1;

    logic [ADDR_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst)        tag_q <= NONE;
        else if (clear) tag_q <= NONE;
        else if (load)  tag_q <= load_base;
    end

    // An aligned base has zero low bits, so it never equals NONE.
    assign hit   = ({probe_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} == tag_q);
    assign valid = (tag_q != NONE);

    p_clear_drops_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !valid);
    p_load_marks_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> valid);

endmodule

// File: rtl/wc_store.sv
module wc_store #(
    parameter int WORDS  = 1024,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= mem_q[rd_idx];
    end

    p_port_apart_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en));

endmodule

// File: rtl/win_read_cache.sv
module win_read_cache
    import win_cache_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    input  logic              inval,
    output logic              fill_req_valid,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_req_ready,
    input  logic              beat_valid,
    input  logic [31:0]       beat_data,
    output logic              beat_ready,
    output logic              mw_valid,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [31:0]       mw_data,
    output logic [2:0]        mw_count,
    input  logic              mw_ready
);
    localparam int WORDS = WIN_BYTES / WORD_BYTES;
    localparam int IDX_W = $clog2(WORDS);
    localparam int OFF_W = $clog2(WIN_BYTES);

    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [31:0]       lat_wdata_q;
    rd_sel_t           sel_q;
    logic [IDX_W-1:0]  beat_cnt_q;
    logic              kill_q;
    logic              rsp_valid_q;

    logic              hit, tag_valid;
    logic              accept, rd_hit_go, last_beat, tag_clear, tag_load;
    logic              rd_en, wr_en;
    logic [IDX_W-1:0]  rd_idx;
    logic [31:0]       rd_word;
    logic [ADDR_W-1:0] win_base;
    acc_size_e         req_sz;

    assign req_sz    = acc_size_e'(req_size);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign rd_hit_go = accept && !req_write && hit;
    assign last_beat = (state_q == ST_FILL_DATA) && beat_valid &&
                       (beat_cnt_q == IDX_W'(WORDS - 1));
    assign win_base  = {lat_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    // A miss allocates: the window is non-resident while it is refilled.
    assign tag_clear = inval || (accept && (req_write || !hit));
    assign tag_load  = last_beat && !kill_q;

    wc_tag #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tag (
        .clk        (clk),
        .rst        (rst),
        .clear      (tag_clear),
        .load       (tag_load),
        .load_base  (win_base),
        .probe_addr (req_addr),
        .hit        (hit),
        .valid      (tag_valid)
    );

    assign rd_en  = rd_hit_go || (state_q == ST_RESP);
    assign rd_idx = (state_q == ST_RESP) ? lat_addr_q[OFF_W-1:2] : req_addr[OFF_W-1:2];
    assign wr_en  = (state_q == ST_FILL_DATA) && beat_valid;

    wc_store #(.WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(32)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (beat_cnt_q),
        .wr_data (beat_data),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) begin
                              if (req_write) state_d = ST_WRITE;
                              else if (!hit) state_d = ST_FILL_REQ;
                          end
            ST_FILL_REQ:  if (fill_req_ready) state_d = ST_FILL_DATA;
            ST_FILL_DATA: if (last_beat) state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            ST_WRITE:     if (mw_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            sel_q       <= '{lane: 2'd0, size: SZ_BYTE};
            beat_cnt_q  <= '0;
            kill_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= rd_en;
            if (accept) begin
                lat_addr_q  <= req_addr;
                lat_wdata_q <= req_wdata;
                sel_q       <= '{lane: req_addr[1:0], size: req_sz};
                kill_q      <= 1'b0;
            end else if (inval && (state_q == ST_FILL_REQ || state_q == ST_FILL_DATA)) begin
                kill_q <= 1'b1;
            end
            if (state_q == ST_FILL_REQ) beat_cnt_q <= '0;
            else if (wr_en)             beat_cnt_q <= beat_cnt_q + 1'b1;
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign rsp_valid      = rsp_valid_q;
    assign rsp_data       = pick_value(rd_word, sel_q);
    assign fill_req_valid = (state_q == ST_FILL_REQ);
    assign fill_addr      = win_base;
    assign beat_ready     = (state_q == ST_FILL_DATA);
    assign mw_valid       = (state_q == ST_WRITE);
    assign mw_addr        = lat_addr_q;
    assign mw_count       = byte_count(sel_q.size);
    assign mw_data        = keep_bytes(lat_wdata_q, mw_count);

    p_miss_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !hit) |=> fill_req_valid);
    p_fill_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_addr)));
    p_rsp_free_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);
    p_hit_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && hit) |=> (rsp_valid && !fill_req_valid));
    p_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
    p_write_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write) |=> !tag_valid);
    p_kill_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (last_beat && kill_q) |=> !tag_valid);

endmodule

// File: tb/test_win_read_cache.sv
`timescale 1ns/1ps
module test_win_read_cache;

    localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2, SX = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        busy, rsp_valid;
    logic [31:0] rsp_data;
    logic        inval = 1'b0;
    logic        fill_req_valid, fill_req_ready = 1'b0;
    logic [31:0] fill_addr;
    logic        beat_valid = 1'b0, beat_ready;
    logic [31:0] beat_data = '0;
    logic        mw_valid, mw_ready = 1'b0;
    logic [31:0] mw_addr, mw_data;
    logic [2:0]  mw_count;

    always #2 clk = ~clk;

    win_read_cache i_win_read_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .inval(inval),
        .fill_req_valid(fill_req_valid), .fill_addr(fill_addr), .fill_req_ready(fill_req_ready),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_count(mw_count), .mw_ready(mw_ready)
    );

    int total = 0, bad = 0, fills = 0;
    logic [31:0] model_w [2048];
    logic [31:0] exp_base = '0;

    typedef struct { logic [31:0] data; string tag; } rsp_item_t;
    typedef struct { logic [31:0] addr; logic [31:0] data; logic [2:0] cnt; } wr_item_t;
    rsp_item_t rq[$];
    wr_item_t  wq[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] a, input logic [1:0] s);
        logic [31:0] w;
        w = model_w[a[12:2]];
        case (s)
            SB: return (w >> (8 * a[1:0])) & 32'hFF;
            SH: return (w >> (16 * a[1])) & 32'hFFFF;
            SW: return w;
            default: return {8'hFF, w[23:0]};
        endcase
    endfunction

    // Memory: window fetch responder with idle gaps between beats.
    initial begin
        bit active = 0, gapped = 0;
        int cnt = 0;
        logic [31:0] base = '0;
        forever begin
            @(negedge clk);
            if (beat_valid) cnt++;
            beat_valid = 1'b0;
            if (fill_req_ready) begin
                fill_req_ready = 1'b0;
                active = 1;
                cnt = 0;
            end else if (fill_req_valid && !active) begin
                fills++;
                check(fill_addr == exp_base, "R2 fill base", fill_addr, exp_base);
                base = fill_addr;
                fill_req_ready = 1'b1;
            end
            if (active) begin
                if (cnt == 1024) active = 0;
                else if ((cnt % 7) == 3 && !gapped) gapped = 1;
                else begin
                    logic [10:0] ix;
                    gapped = 0;
                    ix = base[12:2] + 11'(cnt);
                    beat_valid = 1'b1;
                    beat_data = model_w[ix];
                end
            end
        end
    end

    // Memory: write responder, checks each write against the driver's queue.
    initial begin
        int wait_ctr = 0;
        forever begin
            @(negedge clk);
            if (mw_ready) mw_ready = 1'b0;
            else if (mw_valid) begin
                wait_ctr++;
                if (wait_ctr >= 2) begin
                    wait_ctr = 0;
                    if (wq.size() == 0) check(0, "R7 unexpected write", mw_addr, 0);
                    else begin
                        wr_item_t e;
                        e = wq.pop_front();
                        check(mw_addr == e.addr, "R7 write addr", mw_addr, e.addr);
                        check(mw_data == e.data, "R7 write data", mw_data, e.data);
                        check(mw_count == e.cnt, "R7 write count", 32'(mw_count), 32'(e.cnt));
                        for (int k = 0; k < int'(e.cnt); k++) begin
                            logic [31:0] a;
                            a = e.addr + 32'(k);
                            model_w[a[12:2]][8*a[1:0] +: 8] = e.data[8*k +: 8];
                        end
                    end
                    mw_ready = 1'b1;
                end
            end
        end
    end

    // Monitor: pops expected read values as responses appear.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (rq.size() == 0) check(0, "R3 unexpected response", rsp_data, 0);
                else begin
                    rsp_item_t e;
                    e = rq.pop_front();
                    check(rsp_data == e.data, e.tag, rsp_data, e.data);
                end
            end
        end
    end

    task automatic do_read(input logic [31:0] a, input logic [1:0] s, input int exp_fills,
                           input int inval_at, input string tag);
        int f0;
        rsp_item_t e;
        while (busy) @(negedge clk);
        e.data = model_read(a, s);
        e.tag = tag;
        rq.push_back(e);
        exp_base = {a[31:12], 12'h0};
        f0 = fills;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_fills == 0)
            check(rsp_valid && !busy, {tag, " R4 hit latency"}, 32'(rsp_valid), 1);
        if (inval_at > 0) begin
            repeat (inval_at) @(negedge clk);
            inval = 1'b1;
            @(negedge clk);
            inval = 1'b0;
        end
        while (rq.size() != 0) @(negedge clk);
        check(fills - f0 == exp_fills, {tag, " fill count"}, 32'(fills - f0), 32'(exp_fills));
    endtask

    task automatic do_write(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
        wr_item_t e;
        logic [2:0] n;
        while (busy) @(negedge clk);
        n = (s == SB) ? 3'd1 : (s == SH) ? 3'd2 : (s == SW) ? 3'd4 : 3'd3;
        e.addr = a; e.cnt = n; e.data = '0;
        for (int k = 0; k < int'(n); k++) e.data[8*k +: 8] = d[8*k +: 8];
        wq.push_back(e);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        while (wq.size() != 0 || busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++)
            model_w[i] = (32'(i) * 32'h9E3779B1) ^ (32'(i) << 7) ^ 32'h5A0F3C96;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rsp_valid, "R1 reset idle", {busy, rsp_valid}, 0);
        check(!fill_req_valid && !mw_valid, "R1 reset memory ports", {fill_req_valid, mw_valid}, 0);

        do_read(32'h0000_0010, SW, 1, 0, "R1 R3 first read misses");
        do_read(32'h0000_0013, SB, 0, 0, "R5 byte lane 3");
        do_read(32'h0000_0022, SH, 0, 0, "R5 upper half");
        do_read(32'h0000_0FFF, SB, 0, 0, "R5 last byte of window");
        do_read(32'h0000_0FFC, SW, 0, 0, "R5 last word of window");
        do_read(32'h0000_0040, SX, 0, 0, "R6 colour read");
        do_read(32'h0000_1004, SW, 1, 0, "R2 next window");
        do_read(32'h0000_0008, SW, 1, 0, "R2 back to first window");

        do_write(32'h0000_0009, SB, 32'h1234_56A5);
        do_read(32'h0000_0008, SW, 1, 0, "R8 refetch after byte write");
        do_write(32'h0000_0012, SH, 32'h7777_BEEF);
        do_write(32'h0000_0100, SW, 32'h1234_5678);
        do_write(32'h0000_0104, SX, 32'hCAFE_BABE);
        do_read(32'h0000_0104, SW, 1, 0, "R7 colour write kept top byte");
        do_read(32'h0000_0104, SX, 0, 0, "R6 colour read after write");
        do_read(32'h0000_0012, SH, 0, 0, "R8 half write visible");

        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        do_read(32'h0000_0100, SW, 1, 0, "R9 refetch after invalidate");
        do_read(32'h0000_5010, SW, 1, 0, "R2 distinct base same data");
        do_read(32'hFFFF_FFFC, SW, 1, 0, "R2 top window misses");
        do_read(32'hFFFF_FFFE, SH, 0, 0, "R4 top window hits");

        do_read(32'h0000_1000, SW, 1, 60, "R10 read completes across invalidate");
        do_read(32'h0000_1000, SW, 1, 0, "R10 window left non-resident");
        do_read(32'h0000_1002, SH, 0, 0, "R4 hit after refill");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule